// File: doc/BRIEF.md
# Aggregated Interrupt Cause Controller

This block gathers hardware events from three sources (transmit completion, receive completion and miscellaneous firmware/mailbox conditions) into three cause groups and reduces them to a single interrupt request line. Each group keeps sticky cause bits, a mask that can only be changed through separate set and clear registers, a masked-cause view, a mask read-back, and a clear-mode control that picks at run time whether the cause bits are cleared by writing ones or cleared by reading them.

A summary register above the groups holds one bit per group. A bit is raised while that group has any cause bit that is not masked. The summary register clears when it is read, so software does not have to acknowledge it. A summary mask gates the three summary bits, and the gated result, registered once, drives the interrupt line. Software reaches all of this through a 32-bit word-addressed read/write port. Read data appears on the clock edge that samples the read strobe.

The address map places each group in a 32-byte window: transmit at 0x00, receive at 0x20 and miscellaneous at 0x40. Within a window the word offsets are: cause 0x00, mask set 0x04, mask clear 0x08, clear mode 0x0C, masked view 0x10 and mask value 0x14. The summary cause is at 0x60 and the summary mask at 0x64. The transmit group has 25 bits: bit 0 is general done and bits 1 to 24 are per-ring done. The receive group has one done bit. The miscellaneous group has firmware ready at bit 0, mailbox event at bit 1 and firmware error at bit 2.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every cause bit is 0, every group mask bit is 1, every group is in write-1-to-clear mode (the clear-mode register reads 0), the summary mask reads 0x7, and `irq` is 0.
- R2: An event input bit that is high for one cycle sets its cause bit, and the bit stays set until it is cleared. Cause bits collect events whether masked or not.
- R3: In write-1-to-clear mode, a write to a group's cause register clears the cause bits written as 1 and leaves the other cause bits unchanged.
- R4: In clear-on-read mode, a read of a group's cause register returns the current value and clears all cause bits. Writes to the cause register are ignored in this mode.
- R5: Writing 0xFFFFFFFF to a group's clear-mode register selects clear-on-read. Any other value selects write-1-to-clear. The register reads back 0xFFFFFFFF in clear-on-read mode and 0 otherwise.
- R6: A write to mask-set sets the mask bits written as 1. A write to mask-clear clears the mask bits written as 1. Bits written as 0 keep their value. The mask-value register returns the mask, with a 1 meaning disabled.
- R7: The masked-view register returns cause AND NOT mask.
- R8: The summary cause register has receive at bit 0, transmit at bit 1 and miscellaneous at bit 2. A bit is set on every cycle in which its group has an unmasked cause bit, and it stays set until the summary register is read. A read returns the value and clears it. A group that is still pending sets its bit again.
- R9: The summary mask (1 = disabled) is written directly at 0x64. `irq` is the OR of the live summary bits AND NOT the summary mask, registered once. It therefore follows a cause or mask change after one clock edge.
- R10: An event that arrives in the same cycle as a clear (a write-1-to-clear write or a clear-on-read read) leaves its cause bit set.
- R11: Events that arrive while masked are kept. `irq` rises on the second edge after a mask-clear write that unmasks a pending bit.
- R12: `reg_rdata` is loaded on the edge that samples `reg_rd` and holds its value until the next read. Reads of unused offsets, of unused windows, or with `reg_addr[1:0]` not 0 return 0. Writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tx_evt | input | 25 | Transmit events: bit 0 general done, bits 1..24 ring done |
| rx_evt | input | 1 | Receive done event |
| misc_evt | input | 3 | Firmware ready, mailbox event, firmware error |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted cause or mask bit shows at the ports through three registers at once: the cause read, the masked view and the mask value. It is visible on the very next read, and it also reaches `irq` one edge later through the summary path. A clear that is taken in the wrong mode, or an event lost in the same cycle as a clear, appears as a wrong value on the second read of the same register. A summary latch that fails to clear or fails to re-arm shows in two back-to-back summary reads, and a mistake in the summary mask or the output register shows as `irq` wrong on the second edge after the write.

// File: rtl/irq_cause_pkg.sv
// Package: shared constants and address decode types for the interrupt
// cause controller. Assumes a 32-bit word register port with byte addresses.
package irq_cause_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int SUM_W  = 3;

    // Summary bit positions, read by software from the summary register
    localparam int SUM_RX   = 0;
    localparam int SUM_TX   = 1;
    localparam int SUM_MISC = 2;

    // Word offset inside a group window (reg_addr[4:2])
    typedef enum logic [2:0] {
        OFF_CAUSE = 3'd0,
        OFF_MSET  = 3'd1,
        OFF_MCLR  = 3'd2,
        OFF_MODE  = 3'd3,
        OFF_MVIEW = 3'd4,
        OFF_MVAL  = 3'd5,
        OFF_RSV6  = 3'd6,
        OFF_RSV7  = 3'd7
    } reg_off_e;

    // Window select (reg_addr[7:5])
    typedef enum logic [2:0] {
        WIN_TX   = 3'd0,
        WIN_RX   = 3'd1,
        WIN_MISC = 3'd2,
        WIN_SUM  = 3'd3,
        WIN_RSV4 = 3'd4,
        WIN_RSV5 = 3'd5,
        WIN_RSV6 = 3'd6,
        WIN_RSV7 = 3'd7
    } reg_win_e;
endpackage

// File: rtl/irq_cause_group.sv
// Module: one interrupt cause group. Holds WIDTH sticky cause bits, a mask
// (1 = disabled) changed only via set/clear writes, and a clear-mode flag
// (clear-on-read or write-1-to-clear). Gives a combinational read value for
// the offset presented and a flag that any unmasked cause bit is pending.
// Assumes sel_i already includes the strobe address decode and WIDTH <= 32.
module irq_cause_group
    import irq_cause_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  reg_off_e         off_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [WIDTH-1:0] evt_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             any_o
);
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] clr_vec;
    logic [WIDTH-1:0] wbits;
    logic             cor_q;
    logic             wr_hit;
    logic             rd_hit;

    assign wbits  = wdata_i[WIDTH-1:0];
    assign wr_hit = sel_i && wr_i;
    assign rd_hit = sel_i && rd_i;

    // Clear vector: written ones in write-1-to-clear mode, all bits on a read in clear-on-read mode
    always_comb begin
        clr_vec = '0;
        if (wr_hit && off_i == OFF_CAUSE && !cor_q) clr_vec = clr_vec | wbits;
        if (rd_hit && off_i == OFF_CAUSE &&  cor_q) clr_vec = '1;
    end

    // Cause bits: clear first, then OR in new events so an event is never lost
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | evt_i;
    end

    // Mask bits: set and clear through separate offsets only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_hit && off_i == OFF_MSET) begin
            mask_q <= mask_q | wbits;
        end else if (wr_hit && off_i == OFF_MCLR) begin
            mask_q <= mask_q & ~wbits;
        end
    end

    // Clear mode: an all-ones write selects clear-on-read, anything else write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                            cor_q <= 1'b0;
        else if (wr_hit && off_i == OFF_MODE)  cor_q <= (wdata_i == {REG_W{1'b1}});
    end

    // Read mux for this group's registers
    always_comb begin
        rdata_o = '0;
        case (off_i)
            OFF_CAUSE: rdata_o = REG_W'(cause_q);
            OFF_MODE:  rdata_o = {REG_W{cor_q}};
            OFF_MVIEW: rdata_o = REG_W'(cause_q & ~mask_q);
            OFF_MVAL:  rdata_o = REG_W'(mask_q);
            default:   rdata_o = '0;
        endcase
    end

    // Pending flag toward the summary register
    assign any_o = |(cause_q & ~mask_q);

    assert_evt_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    assert_mset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off_i == OFF_MSET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    assert_mclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off_i == OFF_MCLR) |=> ((mask_q & $past(wbits)) == '0));

    assert_cor_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && off_i == OFF_CAUSE && cor_q && evt_i == '0) |=> (cause_q == '0));

    assert_w1c_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off_i == OFF_CAUSE && !cor_q)
            |=> ((cause_q & ~$past(wbits)) == ($past(cause_q) & ~$past(wbits)) | $past(evt_i)));
endmodule

// File: rtl/irq_cause_summary.sv
// Module: summary cause latch, summary mask and interrupt output register.
// Each summary bit is set while its group reports an unmasked cause and is
// cleared by a read of the summary register; pending groups set it again.
// Assumes any_i comes straight from the group masks (level, not pulse).
module irq_cause_summary
    import irq_cause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] any_i,
    input  logic             rd_clr_i,
    input  logic             wr_mask_i,
    input  logic [SUM_W-1:0] wmask_i,
    output logic [SUM_W-1:0] summ_o,
    output logic [SUM_W-1:0] smask_o,
    output logic             irq_o
);
    logic [SUM_W-1:0] summ_q;
    logic [SUM_W-1:0] smask_q;
    logic             irq_q;

    // Summary latch: cleared by a read, re-armed in the same cycle by pending groups
    always_ff @(posedge clk) begin
        if (!rst_n) summ_q <= '0;
        else        summ_q <= (rd_clr_i ? '0 : summ_q) | any_i;
    end

    // Summary mask: plain write, 1 disables a summary bit
    always_ff @(posedge clk) begin
        if (!rst_n)         smask_q <= '1;
        else if (wr_mask_i) smask_q <= wmask_i;
    end

    // Interrupt line: registered OR of the live summary bits after the mask
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(any_i & ~smask_q);
    end

    assign summ_o  = summ_q;
    assign smask_o = smask_q;
    assign irq_o   = irq_q;

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past((any_i & ~smask_q) != '0));

    assert_summ_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|any_i) |=> ((summ_q & $past(any_i)) == $past(any_i)));

    assert_summ_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i) |=> ((summ_q & $past(summ_q)) == $past(summ_q)));
endmodule

// File: rtl/irq_cause_ctrl.sv
// Module: top of the aggregated interrupt cause controller. Decodes the
// register port into three cause groups and the summary block, registers
// read data, and drives the single interrupt line.
// Assumes reg_wr and reg_rd are single-cycle strobes, one access per cycle.
module irq_cause_ctrl
    import irq_cause_pkg::*;
#(
    parameter int TX_RINGS = 24,
    parameter int RX_BITS  = 1,
    parameter int MISC_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [TX_RINGS:0]   tx_evt,
    input  logic [RX_BITS-1:0]  rx_evt,
    input  logic [MISC_BITS-1:0] misc_evt,
    output logic                irq
);
    localparam int TX_W = TX_RINGS + 1;

    reg_win_e         win;
    reg_off_e         off;
    logic             aligned;
    logic             sel_tx, sel_rx, sel_misc, sel_sum;
    logic [REG_W-1:0] rd_tx, rd_rx, rd_misc, rd_sum, rd_mux;
    logic             any_tx, any_rx, any_misc;
    logic [SUM_W-1:0] any_vec;
    logic [SUM_W-1:0] summ, smask;
    logic             summ_rd_clr, smask_wr;
    logic [REG_W-1:0] rdata_q;

    assign win     = reg_win_e'(reg_addr[7:5]);
    assign off     = reg_off_e'(reg_addr[4:2]);
    assign aligned = (reg_addr[1:0] == 2'b00);

    // Window decode, only for word-aligned addresses
    always_comb begin
        sel_tx   = aligned && win == WIN_TX;
        sel_rx   = aligned && win == WIN_RX;
        sel_misc = aligned && win == WIN_MISC;
        sel_sum  = aligned && win == WIN_SUM;
    end

    irq_cause_group #(.WIDTH(TX_W)) u_grp_tx (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_tx), .wr_i(reg_wr), .rd_i(reg_rd),
        .off_i(off), .wdata_i(reg_wdata), .evt_i(tx_evt),
        .rdata_o(rd_tx), .any_o(any_tx)
    );

    irq_cause_group #(.WIDTH(RX_BITS)) u_grp_rx (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_rx), .wr_i(reg_wr), .rd_i(reg_rd),
        .off_i(off), .wdata_i(reg_wdata), .evt_i(rx_evt),
        .rdata_o(rd_rx), .any_o(any_rx)
    );

    irq_cause_group #(.WIDTH(MISC_BITS)) u_grp_misc (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_misc), .wr_i(reg_wr), .rd_i(reg_rd),
        .off_i(off), .wdata_i(reg_wdata), .evt_i(misc_evt),
        .rdata_o(rd_misc), .any_o(any_misc)
    );

    // Summary bit order seen by software
    always_comb begin
        any_vec           = '0;
        any_vec[SUM_RX]   = any_rx;
        any_vec[SUM_TX]   = any_tx;
        any_vec[SUM_MISC] = any_misc;
    end

    assign summ_rd_clr = reg_rd && sel_sum && off == OFF_CAUSE;
    assign smask_wr    = reg_wr && sel_sum && off == OFF_MSET;

    irq_cause_summary u_sum (
        .clk(clk), .rst_n(rst_n), .any_i(any_vec), .rd_clr_i(summ_rd_clr),
        .wr_mask_i(smask_wr), .wmask_i(reg_wdata[SUM_W-1:0]),
        .summ_o(summ), .smask_o(smask), .irq_o(irq)
    );

    // Summary window read values
    always_comb begin
        case (off)
            OFF_CAUSE: rd_sum = REG_W'(summ);
            OFF_MSET:  rd_sum = REG_W'(smask);
            default:   rd_sum = '0;
        endcase
    end

    // Top-level read mux across windows
    always_comb begin
        rd_mux = '0;
        if (sel_tx)   rd_mux = rd_tx;
        if (sel_rx)   rd_mux = rd_rx;
        if (sel_misc) rd_mux = rd_misc;
        if (sel_sum)  rd_mux = rd_sum;
    end

    // Read data register, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd) |=> $stable(reg_rdata));

    assert_one_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
endmodule

// File: tb/irq_cause_ctrl_tb.sv
`timescale 1ns/1ps
module irq_cause_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [24:0] tx_evt = '0;
    logic [0:0]  rx_evt = '0;
    logic [2:0]  misc_evt = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit pend   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [7:0] TX = 8'h00, RX = 8'h20, MI = 8'h40;
    localparam logic [7:0] O_CAUSE = 8'h00, O_MSET = 8'h04, O_MCLR = 8'h08,
                           O_MODE = 8'h0C, O_VIEW = 8'h10, O_MVAL = 8'h14;
    localparam logic [7:0] S_CAUSE = 8'h60, S_MASK = 8'h64;

    always #2 clk = ~clk;

    irq_cause_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .misc_evt(misc_evt), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected value for the monitor
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(posedge clk); #1;
        chk(irq == e, tag, {31'd0, irq}, {31'd0, e});
    endtask

    // Monitor: compare read data one cycle after the strobe was seen
    always @(negedge clk) begin
        if (pend) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(reg_rdata === e, t, reg_rdata, e);
        end
        pend = reg_rd;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(TX + O_CAUSE, 32'h0, "R1 tx cause");
        rd(TX + O_MVAL, 32'h01FF_FFFF, "R1 tx mask");
        rd(MI + O_MVAL, 32'h7, "R1 misc mask");
        rd(RX + O_MODE, 32'h0, "R1 rx mode");
        rd(S_MASK, 32'h7, "R1 summary mask");

        // R2 events are sticky while masked
        @(posedge clk); #1 tx_evt = 25'h5;
        @(posedge clk); #1 tx_evt = '0;
        rd(TX + O_CAUSE, 32'h5, "R2 tx cause sticky");
        chk(irq == 1'b0, "R2 irq masked", {31'd0, irq}, 32'd0);
        rd(S_CAUSE, 32'h0, "R8 summary masked group");

        // R6 mask clear, R7 masked view
        wr(TX + O_MCLR, 32'h1);
        rd(TX + O_MVAL, 32'h01FF_FFFE, "R6 mask clear");
        rd(TX + O_VIEW, 32'h1, "R7 masked view");
        rd(S_CAUSE, 32'h2, "R8 tx summary bit");
        rd(S_CAUSE, 32'h2, "R8 summary rearmed");
        chk(irq == 1'b0, "R9 summary mask blocks irq", {31'd0, irq}, 32'd0);

        // R9/R11 open the summary mask
        wr(S_MASK, 32'hFFFF_FFF8);
        irq_chk(1'b1, "R11 irq after unmask");
        rd(S_MASK, 32'h0, "R9 summary mask readback");

        // R3 write-1-to-clear of bit 0 only
        wr(TX + O_CAUSE, 32'h1);
        irq_chk(1'b0, "R3 irq drops after clear");
        rd(TX + O_CAUSE, 32'h4, "R3 other bit kept");
        rd(S_CAUSE, 32'h2, "R8 latched until read");
        rd(S_CAUSE, 32'h0, "R8 cleared by read");

        // R6 zero bits leave the mask unchanged
        wr(TX + O_MSET, 32'h0);
        rd(TX + O_MVAL, 32'h01FF_FFFE, "R6 zero write no effect");
        wr(TX + O_MSET, 32'h1);
        rd(TX + O_MVAL, 32'h01FF_FFFF, "R6 mask set");

        // R5/R4 clear-on-read mode
        wr(TX + O_MODE, 32'hFFFF_FFFF);
        rd(TX + O_MODE, 32'hFFFF_FFFF, "R5 mode cor readback");
        wr(TX + O_CAUSE, 32'h4);
        rd(TX + O_CAUSE, 32'h4, "R4 write ignored, read returns");
        rd(TX + O_CAUSE, 32'h0, "R4 cleared by read");
        wr(TX + O_MODE, 32'h1);
        rd(TX + O_MODE, 32'h0, "R5 non-all-ones gives w1c");

        // R10 event wins over write-1-to-clear
        @(posedge clk); #1 misc_evt = 3'h2;
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = MI + O_CAUSE; reg_wdata = 32'h2;
        @(posedge clk); #1;
        reg_wr = 1'b0; misc_evt = '0;
        rd(MI + O_CAUSE, 32'h2, "R10 event wins w1c");
        wr(MI + O_CAUSE, 32'h2);
        rd(MI + O_CAUSE, 32'h0, "R3 misc cleared");

        // R10 event wins over clear-on-read
        wr(RX + O_MODE, 32'hFFFF_FFFF);
        @(posedge clk); #1 rx_evt = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = RX + O_CAUSE;
        exp_q.push_back(32'h1); tag_q.push_back("R10 cor read with event");
        @(posedge clk); #1;
        reg_rd = 1'b0; rx_evt = 1'b0;
        rd(RX + O_CAUSE, 32'h1, "R10 event kept after cor read");
        rd(RX + O_CAUSE, 32'h0, "R4 rx cleared");

        // R12 unmapped and misaligned accesses
        rd(8'h7C, 32'h0, "R12 unused window");
        rd(MI + 8'h18, 32'h0, "R12 unused offset");
        rd(TX + O_MVAL + 8'h1, 32'h0, "R12 misaligned");
        wr(TX + O_MCLR + 8'h2, 32'hFFFF_FFFF);
        rd(TX + O_MVAL, 32'h01FF_FFFF, "R12 misaligned write ignored");

        // R8/R9 misc source through to irq, then disable
        wr(MI + O_MCLR, 32'h4);
        @(posedge clk); #1 misc_evt = 3'h4;
        @(posedge clk); #1 misc_evt = '0;
        irq_chk(1'b1, "R9 misc irq");
        rd(S_CAUSE, 32'h4, "R8 misc summary bit");
        wr(S_MASK, 32'hFFFF_FFFF);
        irq_chk(1'b0, "R9 all-ones mask disables irq");

        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule